// File: doc/BRIEF.md
# Parallel Converter Sampling Sequencer

This block sits on the host side of a 14-bit successive-approximation converter that has a parallel output bus. It paces conversions at a programmable rate and raises the conversion-start strobe for a fixed minimum width. It then watches the converter's busy line until the conversion completes, runs one chip-select/read strobe cycle on the data bus, and captures the word once the converter's access time has passed. Each result is handed on as a sign-extended sample with a single-cycle valid strobe.

Every timing rule of the converter is a whole number of host clock cycles. Each is derived at elaboration from a nanosecond figure and the host clock period, and rounded up. These rules are the start pulse width, the window in which busy may still be rising, the read-low width, the data access time (which has a longer variant for a low-voltage bus) and the bus release gap. A conversion whose busy line never falls is abandoned after a bounded wait and reported with an error pulse. The busy line is asynchronous to the host clock, so it passes through a synchronizer first.

Top module: `adc_rdctl`

## Requirements
- R1: While reset is held and right after it is released, the start strobe is low, chip-select and read (both active low) are high, the valid strobe and error pulse are low, and the sample output is zero.
- R2: Each start strobe stays high for exactly START_CYC = ceil(35 ns / clock period) cycles (9 at 250 MHz).
- R3: A read never begins before the converter has dropped busy for the current conversion. Busy is ignored for the first ceil(70 ns / clock period) cycles after the start strobe rises, plus the synchronizer depth, so a busy line that rises late in that window cannot be mistaken for completion.
- R4: Chip-select and read fall in the same cycle and rise in the same cycle. Read stays low for exactly RD_CYC cycles, the larger of ceil(35 ns / period) and the access-time count (9 at 250 MHz on a 5 V bus).
- R5: The bus is sampled in the last cycle of the read-low pulse, at least the access time (ceil(35 ns / period), or 40 ns for a low-voltage bus) after read falls. The 14-bit twos-complement word appears on the 16-bit output with bit 13 copied into bits 15:14. The valid strobe is high for exactly one cycle, the cycle in which read returns high, and never at any other time.
- R6: While run is held high and conversions complete normally, consecutive start strobes rise exactly max(period_i, MIN_PER) cycles apart. MIN_PER = ceil(2500 ns / period) = 625 cycles, the 400 kSPS limit.
- R7: If busy has not fallen after TO_CYC = ceil(4400 ns / period) = 1100 cycles of waiting, the error pulse is high for one cycle exactly 20 + 1100 cycles after the start strobe rose. No read and no sample are produced for that conversion.
- R8: With run low, no start strobe is issued. A conversion already under way completes. When run is raised while the block is idle and the pacing interval has already elapsed, the start strobe rises on the next clock edge.
- R9: A read begins exactly SYNC_STAGES + 1 clock edges after busy is first sampled low (3 with the default two-stage synchronizer).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Allows new conversions to start |
| period_i | input | PER_W (16) | Start-to-start interval in cycles; values below MIN_PER are raised to it |
| busy_i | input | 1 | Converter busy indication, asynchronous |
| bus_d_i | input | DATA_W (14) | Converter parallel data bus |
| convst_o | output | 1 | Conversion-start strobe, active high |
| cs_n_o | output | 1 | Converter chip-select, active low |
| rd_n_o | output | 1 | Converter read strobe, active low |
| smp_valid_o | output | 1 | One-cycle strobe marking a new sample |
| smp_data_o | output | OUT_W (16) | Sign-extended sample |
| timeout_o | output | 1 | One-cycle pulse when a conversion never completes |

## Verification
The converter model in the bench can raise busy as late as the end of the permitted window. A sequencer that checks for completion too early would read a stale bus there, and the bench catches that. The model keeps the bus at the inverted word until the access count has elapsed, so sampling one cycle early shows up as a data mismatch. The directed words are the most negative code, the largest positive code, zero and all-ones, which expose a sign extension that copies the wrong bit or none. One conversion is made to hang. A wrong timeout bound, a stray read or a sample on that conversion shows up as a wrong error-pulse cycle or an extra valid strobe. Programmed intervals below the 400 kSPS floor check that the clamp is applied and not the raw value.

// File: rtl/adc_rdctl_pkg.sv
package adc_rdctl_pkg;

   typedef enum logic [2:0] {
      ST_PACE,
      ST_START,
      ST_BLANK,
      ST_WAIT,
      ST_READ,
      ST_RELQ
   } rdctl_st_e;

   // whole clock cycles covering a time in ns, rounded up
   function automatic int ns_to_cyc(input int t_ns, input int clk_ps);
      return (t_ns * 1000 + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/adc_rdctl_sync.sv
module adc_rdctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} & {STAGES{1'b1}};
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/adc_rdctl_tmr.sv
module adc_rdctl_tmr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/adc_rdctl_pace.sv
module adc_rdctl_pace #(
   parameter int PER_W   = 16,
   parameter int MIN_PER = 625
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PER_W-1:0] period_i,
   output logic             due
);

   localparam logic [PER_W-1:0] MIN_V = PER_W'(MIN_PER);

   logic [PER_W-1:0] pcnt;
   logic [PER_W-1:0] eff;

   // count from the last start, saturating so a long idle leaves it due
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pcnt <= '1;
      else if (restart)       pcnt <= PER_W'(1);
      else if (pcnt != '1)    pcnt <= pcnt + 1'b1;
   end

   assign eff = (period_i < MIN_V) ? MIN_V : period_i;
   assign due = (pcnt >= eff);

endmodule

// File: rtl/adc_rdctl_cap.sv
module adc_rdctl_cap #(
   parameter int DATA_W = 14,
   parameter int OUT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] bus_d,
   output logic              valid,
   output logic [OUT_W-1:0]  word
);

   logic [OUT_W-1:0] ext;

   generate
      if (OUT_W == DATA_W) begin : g_same
         assign ext = bus_d;
      end else begin : g_sext
         assign ext = {{(OUT_W-DATA_W){bus_d[DATA_W-1]}}, bus_d};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         word  <= '0;
      end else begin
         valid <= cap;
         if (cap) word <= ext;
      end
   end

endmodule

// File: rtl/adc_rdctl.sv
module adc_rdctl
   import adc_rdctl_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 4000,
   parameter int DATA_W        = 14,
   parameter int OUT_W         = 16,
   parameter int PER_W         = 16,
   parameter int SYNC_STAGES   = 2,
   parameter bit LOW_VOLT_BUS  = 1'b0,
   parameter int T_START_NS    = 35,
   parameter int T_BUSY_NS     = 70,
   parameter int T_RDPW_NS     = 35,
   parameter int T_ACC_NS      = 35,
   parameter int T_ACC_LV_NS   = 40,
   parameter int T_RELQ_NS     = 30,
   parameter int T_SAMPLE_NS   = 2500,
   parameter int T_TIMEOUT_NS  = 4400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [PER_W-1:0]  period_i,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] bus_d_i,
   output logic              convst_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              smp_valid_o,
   output logic [OUT_W-1:0]  smp_data_o,
   output logic              timeout_o
);

   localparam int START_CYC = imax(1, ns_to_cyc(T_START_NS, CLK_PERIOD_PS));
   localparam int BUSY_CYC  = ns_to_cyc(T_BUSY_NS, CLK_PERIOD_PS);
   localparam int RDPW_CYC  = ns_to_cyc(T_RDPW_NS, CLK_PERIOD_PS);
   localparam int ACC_CYC   = LOW_VOLT_BUS ? ns_to_cyc(T_ACC_LV_NS, CLK_PERIOD_PS)
                                           : ns_to_cyc(T_ACC_NS, CLK_PERIOD_PS);
   localparam int RD_CYC    = imax(1, imax(RDPW_CYC, ACC_CYC));
   localparam int RELQ_CYC  = imax(1, ns_to_cyc(T_RELQ_NS, CLK_PERIOD_PS));
   localparam int BLANK_CYC = imax(1, BUSY_CYC + SYNC_STAGES - START_CYC);
   localparam int MIN_PER   = ns_to_cyc(T_SAMPLE_NS, CLK_PERIOD_PS);
   localparam int TO_CYC    = imax(1, ns_to_cyc(T_TIMEOUT_NS, CLK_PERIOD_PS));
   localparam int TMR_MAX   = imax(imax(START_CYC, BLANK_CYC), imax(imax(TO_CYC, RD_CYC), RELQ_CYC));
   localparam int TMR_W     = $clog2(TMR_MAX + 1);

   generate
      if (OUT_W < DATA_W) begin : g_bad_out_w
         $error("adc_rdctl: OUT_W must not be narrower than DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("adc_rdctl: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("adc_rdctl: SYNC_STAGES must lie in 0..4");
      end
      if (MIN_PER >= (1 << PER_W) - 1) begin : g_bad_per_w
         $error("adc_rdctl: PER_W too narrow for the minimum sample interval");
      end
      if (CLK_PERIOD_PS <= 0) begin : g_bad_clk
         $error("adc_rdctl: CLK_PERIOD_PS must be positive");
      end
   endgenerate

   logic             busy_s;
   rdctl_st_e        st_q, st_d;
   logic             tmr_ld;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_zero;
   logic             pace_due;
   logic             cap_go;
   logic             to_hit;
   logic             timeout_q;

   adc_rdctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (busy_i),
      .q     (busy_s)
   );

   adc_rdctl_tmr #(.W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_ld),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   adc_rdctl_pace #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_pace (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (st_q == ST_PACE && st_d == ST_START),
      .period_i (period_i),
      .due      (pace_due)
   );

   adc_rdctl_cap #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap_go),
      .bus_d (bus_d_i),
      .valid (smp_valid_o),
      .word  (smp_data_o)
   );

   // each timed state loads N-1 on entry and leaves when the timer is zero
   always_comb begin
      st_d    = st_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      cap_go  = 1'b0;
      to_hit  = 1'b0;
      unique case (st_q)
         ST_PACE: begin
            if (run_i && pace_due) begin
               st_d    = ST_START;
               tmr_ld  = 1'b1;
               tmr_val = TMR_W'(START_CYC - 1);
            end
         end
         ST_START: begin
            if (tmr_zero) begin
               st_d    = ST_BLANK;
               tmr_ld  = 1'b1;
               tmr_val = TMR_W'(BLANK_CYC - 1);
            end
         end
         ST_BLANK: begin
            if (tmr_zero) begin
               st_d    = ST_WAIT;
               tmr_ld  = 1'b1;
               tmr_val = TMR_W'(TO_CYC - 1);
            end
         end
         ST_WAIT: begin
            if (!busy_s) begin
               st_d    = ST_READ;
               tmr_ld  = 1'b1;
               tmr_val = TMR_W'(RD_CYC - 1);
            end else if (tmr_zero) begin
               st_d    = ST_PACE;
               to_hit  = 1'b1;
            end
         end
         ST_READ: begin
            if (tmr_zero) begin
               st_d    = ST_RELQ;
               cap_go  = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = TMR_W'(RELQ_CYC - 1);
            end
         end
         ST_RELQ: begin
            if (tmr_zero) st_d = ST_PACE;
         end
         default: st_d = ST_PACE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_PACE;
         timeout_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         timeout_q <= to_hit;
      end
   end

   assign convst_o  = (st_q == ST_START);
   assign rd_n_o    = (st_q != ST_READ);
   assign cs_n_o    = (st_q != ST_READ);
   assign timeout_o = timeout_q;

endmodule

// File: rtl/adc_rdctl_chk.sv
module adc_rdctl_chk #(
   parameter int START_CYC = 9,
   parameter int RD_CYC    = 9
) (
   input logic clk,
   input logic rst_n,
   input logic convst_o,
   input logic cs_n_o,
   input logic rd_n_o,
   input logic smp_valid_o,
   input logic timeout_o
);

   logic [15:0] hi_len;
   logic [15:0] rd_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_len <= '0;
         rd_len <= '0;
      end else begin
         hi_len <= convst_o ? hi_len + 1'b1 : '0;
         rd_len <= !rd_n_o ? rd_len + 1'b1 : '0;
      end
   end

   a_r2_start_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(convst_o) |-> (hi_len == 16'(START_CYC)));

   a_r4_read_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n_o) |-> (rd_len == 16'(RD_CYC)));

   a_r4_cs_falls_with_rd: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n_o) |-> !cs_n_o);

   a_r4_cs_rises_with_rd: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_n_o) |-> cs_n_o);

   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid_o |=> !smp_valid_o);

   a_r5_valid_at_read_end: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid_o |-> $rose(rd_n_o));

   a_r7_timeout_single: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |=> !timeout_o);

   a_r7_no_sample_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (rd_n_o && !smp_valid_o));

   a_r3_no_start_during_read: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n_o |-> !convst_o);

endmodule

bind adc_rdctl adc_rdctl_chk #(
   .START_CYC (START_CYC),
   .RD_CYC    (RD_CYC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .convst_o    (convst_o),
   .cs_n_o      (cs_n_o),
   .rd_n_o      (rd_n_o),
   .smp_valid_o (smp_valid_o),
   .timeout_o   (timeout_o)
);

// File: tb/sim_adc_rdctl.sv
`timescale 1ns/1ps
module sim_adc_rdctl;

   localparam int CLK_PS    = 4000;
   localparam int SYNC      = 2;
   localparam int START_CYC = 9;
   localparam int RD_CYC    = 9;
   localparam int ACC_CYC   = 9;
   localparam int WAIT_AT   = 20;
   localparam int TO_CYC    = 1100;
   localparam int MIN_PER   = 625;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 1'b0;
   logic [15:0] period_i = '0;
   logic        busy_i = 1'b0;
   logic [13:0] bus_d_i = '0;
   logic        convst_o, cs_n_o, rd_n_o, smp_valid_o, timeout_o;
   logic [15:0] smp_data_o;

   always #2 clk = ~clk;

   adc_rdctl #(.CLK_PERIOD_PS(CLK_PS), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .period_i(period_i),
      .busy_i(busy_i), .bus_d_i(bus_d_i), .convst_o(convst_o), .cs_n_o(cs_n_o),
      .rd_n_o(rd_n_o), .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o),
      .timeout_o(timeout_o)
   );

   int nchk = 0, nerr = 0;
   int nrise = 0, nval = 0, nto = 0;
   bit hang_req = 1'b0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sext(input logic [13:0] w);
      return {{2{w[13]}}, w};
   endfunction

   function automatic int eff_per(input logic [15:0] p);
      return (int'(p) < MIN_PER) ? MIN_PER : int'(p);
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // converter model and output monitor in one process
   longint cyc = 0, rise_cyc = 0, rd_fall = 0, m_busy_at = -1, m_fall_at = -1, m_fall_cyc = 0;
   bit p_cv = 0, p_rd = 1, p_val = 0, have_rise = 0, skip_gap = 0, seen_val = 0;
   bit m_active = 0, m_done = 0;
   int rdcnt = 0;
   logic [13:0] m_word = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (convst_o && !p_cv) begin
            if (have_rise && !skip_gap)
               chk(cyc - rise_cyc == eff_per(period_i), "R6 start spacing", cyc - rise_cyc, eff_per(period_i));
            have_rise = 1; skip_gap = 0; rise_cyc = cyc; nrise++; seen_val = 0;
            m_active = 1; m_done = 0;
            m_busy_at = cyc + ((nrise <= 4) ? 17 : 1 + ($urandom % 17));
            m_fall_at = hang_req ? cyc + 100000 : m_busy_at + 150 + ($urandom % 300);
            hang_req = 0;
            case (nrise)
               1: m_word = 14'h2000;
               2: m_word = 14'h1FFF;
               3: m_word = 14'h0000;
               4: m_word = 14'h3FFF;
               default: m_word = 14'($urandom);
            endcase
         end
         if (m_active && cyc == m_busy_at) busy_i <= 1'b1;
         if (m_active && cyc == m_fall_at) begin
            busy_i <= 1'b0; m_active = 0; m_done = 1; m_fall_cyc = cyc;
         end
         if (!convst_o && p_cv)
            chk(cyc - rise_cyc == START_CYC, "R2 start width", cyc - rise_cyc, START_CYC);
         if (!rd_n_o && p_rd) begin
            chk(m_done, "R3 read before busy fell", 0, 1);
            chk(cyc - m_fall_cyc == SYNC + 1, "R9 busy-to-read latency", cyc - m_fall_cyc, SYNC + 1);
            chk(!cs_n_o, "R4 cs falls with rd", cs_n_o, 0);
            rd_fall = cyc;
         end
         rdcnt = !rd_n_o ? rdcnt + 1 : 0;
         bus_d_i <= (rdcnt >= ACC_CYC) ? m_word : ~m_word;
         if (rd_n_o && !p_rd) begin
            chk(cyc - rd_fall == RD_CYC, "R4 read width", cyc - rd_fall, RD_CYC);
            chk(cs_n_o, "R4 cs rises with rd", cs_n_o, 1);
            chk(smp_valid_o, "R5 valid at read end", smp_valid_o, 1);
            chk(smp_data_o == sext(m_word), "R5 sample value", smp_data_o, sext(m_word));
         end else if (smp_valid_o) begin
            chk(0, "R5 stray valid", 1, 0);
         end
         if (smp_valid_o && p_val) chk(0, "R5 valid longer than one cycle", 1, 0);
         if (smp_valid_o) begin nval++; seen_val = 1; end
         if (timeout_o) begin
            chk(cyc - rise_cyc == WAIT_AT + TO_CYC, "R7 timeout cycle", cyc - rise_cyc, WAIT_AT + TO_CYC);
            chk(!seen_val, "R7 no sample on hung conversion", seen_val, 0);
            nto++; skip_gap = 1;
         end
         if (!run_i) have_rise = 0;
         p_cv = convst_o; p_rd = rd_n_o; p_val = smp_valid_o;
      end
   end

   bit done = 0;

   initial begin
      int nr;
      void'($urandom(32'h00C0FFEE));
      repeat (5) tick();
      chk(!convst_o && cs_n_o && rd_n_o, "R1 strobes in reset", {convst_o, cs_n_o, rd_n_o}, 3'b011);
      rst_n = 1'b1;
      repeat (3) tick();
      chk(!convst_o && cs_n_o && rd_n_o, "R1 strobes after reset", {convst_o, cs_n_o, rd_n_o}, 3'b011);
      chk(!smp_valid_o && !timeout_o, "R1 pulses after reset", {smp_valid_o, timeout_o}, 0);
      chk(smp_data_o == 16'h0, "R1 sample after reset", smp_data_o, 0);
      repeat (50) tick();
      chk(nrise == 0, "R8 no start while run low", nrise, 0);
      period_i = 16'd0;
      run_i = 1'b1;
      while (nval < 6) tick();
      period_i = 16'd624;
      nr = nval;
      while (nval < nr + 2) tick();
      period_i = 16'd700;
      while (nval < 10) tick();
      while (nval < 14) begin
         nr = nval;
         while (nval == nr) tick();
         period_i = 16'(626 + ($urandom % 275));
      end
      hang_req = 1'b1;
      while (nto < 1) tick();
      nr = nval;
      while (nval < nr + 2) tick();
      run_i = 1'b0;
      nr = nrise;
      repeat (1500) tick();
      chk(nrise == nr, "R8 no start after run dropped", nrise, nr);
      run_i = 1'b1;
      repeat (2) tick();
      chk(nrise == nr + 1, "R8 immediate start on run", nrise, nr + 1);
      nr = nval;
      while (nval < nr + 2) tick();
      repeat (5) tick();
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", nval, 0);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule